// File: doc/BRIEF.md
# UART Modem Flow Control Unit

This block sits beside the serializers of a serial port and makes the flow decisions for the line. It drives the request-to-send pin either straight from a software bit or, in automatic mode, from the receive FIFO occupancy compared against a programmable 4-bit threshold. It also holds the transmitter off while clear-to-send is deasserted. It forces a break on the transmit line, gates the receive and transmit directions, and reports clear-to-send status, a sticky clear-to-send change flag and a transmitter-fully-idle indication.

The control fields arrive as one 13-bit word from the port's control register. Only the listed bit positions carry meaning. The receive FIFO count arrives from the FIFO storage. The transmit serializer signals each character boundary and whether its shifter is idle. The serializers and the FIFO storage themselves lie outside this block.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, while reset is held: rts_n = 1, tx_hold = 0, brk_force = 0, rx_en = 0, tx_en = 0, cts_changed = 0, cts_off = 1, tx_all_idle = 0.
- R2: With ctrl[12] = 0 (manual mode), rts_n equals ctrl[9] one clock later (1 = deasserted, 0 = asserted), whatever the value of rx_count.
- R3: With ctrl[12] = 1 and ctrl[9] = 0, rts_n is 1 one clock after rx_count >= ctrl[4:1], and 0 one clock after rx_count < ctrl[4:1].
- R4: ctrl[9] = 1 keeps rts_n at 1 in automatic mode for every rx_count.
- R5: cts_n_pin passes through two synchronizer flops. cts_off (1 = deasserted) follows the pin after the second clock edge.
- R6: Any edge on the synchronized clear-to-send sets cts_changed at the third edge after the pin change. The flag stays set until a cts_chg_clr pulse clears it one clock later; a new edge in the same cycle wins over the clear.
- R7: With ctrl[11] = 1 and clear-to-send deasserted, tx_hold rises only in the cycle after tx_char_done is high. It drops one clock after the synchronized clear-to-send becomes asserted.
- R8: With ctrl[11] = 0, tx_hold stays 0 even while clear-to-send is deasserted and tx_char_done pulses.
- R9: brk_force equals ctrl[0] one clock later.
- R10: rx_en is the inverse of ctrl[8], and tx_en is the inverse of ctrl[7], each one clock later.
- R11: tx_all_idle is 1 one clock after both tx_fifo_empty and tx_shift_idle are 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 13 | Flow control fields (bit positions as in the requirements) |
| rx_count | input | RX_CNT_W | Receive FIFO occupancy |
| cts_n_pin | input | 1 | Clear-to-send pin, low = asserted, asynchronous |
| cts_chg_clr | input | 1 | Pulse that clears the change flag |
| tx_char_done | input | 1 | Transmit serializer is at a character boundary |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_idle | input | 1 | Transmit shifter is idle |
| rts_n | output | 1 | Request-to-send pin, low = asserted |
| tx_hold | output | 1 | Stop the transmitter before its next character |
| brk_force | output | 1 | Drive the transmit line continuously low |
| rx_en | output | 1 | Receive direction enabled |
| tx_en | output | 1 | Transmit direction enabled |
| cts_off | output | 1 | Synchronized clear-to-send status, 1 = deasserted |
| cts_changed | output | 1 | Sticky clear-to-send edge flag |
| tx_all_idle | output | 1 | Transmitter fully idle |

## Verification
The automatic request-to-send path is swept over every threshold from 0 to 15 against every FIFO count from 0 to 16. This separates an off-by-one in the comparison from a wrong field slice, and it shows that threshold 0 always deasserts. The same count sweep is repeated in manual mode and with the software override set, to show that the count has no effect there. The clear-to-send path is driven with single edges in both directions and sampled at every cycle around them, which exposes a missing or extra synchronizer stage and a hold taken off the character boundary. The direction-disable, break and idle inputs are swept through every combination, so that crossed bits show up.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
    localparam int THR_W       = 4;
    localparam int CTRL_W      = 13;
    localparam int BIT_AUTO    = 12;
    localparam int BIT_CTSGATE = 11;
    localparam int BIT_SWRTS   = 9;
    localparam int BIT_RXOFF   = 8;
    localparam int BIT_TXOFF   = 7;
    localparam int BIT_THR_LO  = 1;
    localparam int BIT_BRK     = 0;

    typedef struct packed {
        logic             auto_rts;
        logic             cts_gate;
        logic             sw_rts_off;
        logic             rx_off;
        logic             tx_off;
        logic [THR_W-1:0] thr;
        logic             brk;
    } flow_cfg_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic brk;
    } line_ctl_t;

    function automatic flow_cfg_t decode_cfg(input logic [CTRL_W-1:0] w);
        flow_cfg_t c;
        c.auto_rts   = w[BIT_AUTO];
        c.cts_gate   = w[BIT_CTSGATE];
        c.sw_rts_off = w[BIT_SWRTS];
        c.rx_off     = w[BIT_RXOFF];
        c.tx_off     = w[BIT_TXOFF];
        c.thr        = w[BIT_THR_LO +: THR_W];
        c.brk        = w[BIT_BRK];
        return c;
    endfunction
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic chg_clr,
    output logic cts_off,
    output logic changed
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= pin_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign cts_off = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= 1'b1;
            changed <= 1'b0;
        end else begin
            prev <= cts_off;
            if (prev != cts_off) changed <= 1'b1;
            else if (chg_clr)    changed <= 1'b0;
        end
    end
endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl
    import uart_flow_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_rts,
    input  logic             sw_rts_off,
    input  logic [THR_W-1:0] thr,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rts_n
);
    logic at_limit;
    assign at_limit = (rx_count >= CNT_W'(thr));

    always_ff @(posedge clk) begin
        if (rst) rts_n <= 1'b1;
        else     rts_n <= sw_rts_off | (auto_rts & at_limit);
    end
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
    import uart_flow_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flow_cfg_t cfg,
    input  logic      cts_off,
    input  logic      char_done,
    input  logic      fifo_empty,
    input  logic      shift_idle,
    output logic      hold,
    output line_ctl_t line,
    output logic      all_idle
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= 1'b0;
            line     <= '0;
            all_idle <= 1'b0;
        end else begin
            hold       <= cfg.cts_gate & cts_off & (hold | char_done);
            line.rx_en <= ~cfg.rx_off;
            line.tx_en <= ~cfg.tx_off;
            line.brk   <= cfg.brk;
            all_idle   <= fifo_empty & shift_idle;
        end
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_flow_pkg::*;
#(
    parameter int RX_CNT_W    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic [RX_CNT_W-1:0] rx_count,
    input  logic                cts_n_pin,
    input  logic                cts_chg_clr,
    input  logic                tx_char_done,
    input  logic                tx_fifo_empty,
    input  logic                tx_shift_idle,
    output logic                rts_n,
    output logic                tx_hold,
    output logic                brk_force,
    output logic                rx_en,
    output logic                tx_en,
    output logic                cts_off,
    output logic                cts_changed,
    output logic                tx_all_idle
);
    flow_cfg_t cfg;
    line_ctl_t line;

    assign cfg = decode_cfg(ctrl);

    flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_n(cts_n_pin), .chg_clr(cts_chg_clr),
        .cts_off(cts_off), .changed(cts_changed)
    );

    flow_rts_ctrl #(.CNT_W(RX_CNT_W)) u_rts (
        .clk(clk), .rst(rst), .auto_rts(cfg.auto_rts),
        .sw_rts_off(cfg.sw_rts_off), .thr(cfg.thr),
        .rx_count(rx_count), .rts_n(rts_n)
    );

    flow_tx_gate u_gate (
        .clk(clk), .rst(rst), .cfg(cfg), .cts_off(cts_off),
        .char_done(tx_char_done), .fifo_empty(tx_fifo_empty),
        .shift_idle(tx_shift_idle), .hold(tx_hold), .line(line),
        .all_idle(tx_all_idle)
    );

    assign rx_en     = line.rx_en;
    assign tx_en     = line.tx_en;
    assign brk_force = line.brk;
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk
    import uart_flow_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl,
    input logic              cts_chg_clr,
    input logic              tx_char_done,
    input logic              rts_n,
    input logic              tx_hold,
    input logic              brk_force,
    input logic              rx_en,
    input logic              cts_changed
);
    p_sw_rts_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl[BIT_SWRTS] |=> rts_n);
    p_brk_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl[BIT_BRK] |=> brk_force);
    p_rx_off_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl[BIT_RXOFF] |=> !rx_en);
    p_hold_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> $past(tx_char_done));
    p_hold_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl[BIT_CTSGATE] |=> !tx_hold);
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (cts_changed && !cts_chg_clr) |=> cts_changed);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .cts_chg_clr(cts_chg_clr),
    .tx_char_done(tx_char_done), .rts_n(rts_n), .tx_hold(tx_hold),
    .brk_force(brk_force), .rx_en(rx_en), .cts_changed(cts_changed)
);

// File: tb/uart_flow_ctrl_tb_top.sv
module uart_flow_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] ctrl = '0;
    logic [4:0]  rx_count = '0;
    logic        cts_n_pin = 1'b1;
    logic        cts_chg_clr = 1'b0;
    logic        tx_char_done = 1'b0;
    logic        tx_fifo_empty = 1'b0;
    logic        tx_shift_idle = 1'b0;
    logic rts_n, tx_hold, brk_force, rx_en, tx_en, cts_off, cts_changed, tx_all_idle;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_flow_ctrl dut_i (
        .clk(clk), .rst(rst), .ctrl(ctrl), .rx_count(rx_count),
        .cts_n_pin(cts_n_pin), .cts_chg_clr(cts_chg_clr),
        .tx_char_done(tx_char_done), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_idle(tx_shift_idle), .rts_n(rts_n), .tx_hold(tx_hold),
        .brk_force(brk_force), .rx_en(rx_en), .tx_en(tx_en),
        .cts_off(cts_off), .cts_changed(cts_changed), .tx_all_idle(tx_all_idle)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [12:0] mk(input logic auto_m, input logic gate,
        input logic sw, input logic rxo, input logic txo,
        input logic [3:0] thr, input logic brk);
        logic [12:0] w;
        w = '0;
        w[12] = auto_m; w[11] = gate; w[9] = sw; w[8] = rxo; w[7] = txo;
        w[4:1] = thr; w[0] = brk;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 rts_n", rts_n, 1);
        chk("R1 tx_hold", tx_hold, 0);
        chk("R1 brk_force", brk_force, 0);
        chk("R1 rx_en", rx_en, 0);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 cts_changed", cts_changed, 0);
        chk("R1 cts_off", cts_off, 1);
        chk("R1 tx_all_idle", tx_all_idle, 0);
        rst = 1'b0;
        step();

        // R2 manual mode: count has no effect
        for (int sw = 0; sw < 2; sw++) begin
            for (int c = 0; c <= 16; c++) begin
                ctrl = mk(0, 0, sw[0], 0, 0, 4'd3, 0);
                rx_count = 5'(c);
                step();
                chk("R2 manual rts_n", rts_n, sw);
            end
        end

        // R3 automatic threshold sweep
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c <= 16; c++) begin
                ctrl = mk(1, 0, 0, 0, 0, 4'(t), 0);
                rx_count = 5'(c);
                step();
                chk("R3 auto rts_n", rts_n, (c >= t) ? 1 : 0);
            end
        end

        // R4 software override in automatic mode
        for (int c = 0; c <= 16; c++) begin
            ctrl = mk(1, 0, 1, 0, 0, 4'd8, 0);
            rx_count = 5'(c);
            step();
            chk("R4 override rts_n", rts_n, 1);
        end

        // R5 / R6 synchronizer and sticky change flag
        ctrl = '0;
        cts_n_pin = 1'b0;
        step();
        chk("R5 cts_off after 1 edge", cts_off, 1);
        step();
        chk("R5 cts_off after 2 edges", cts_off, 0);
        chk("R6 flag not yet", cts_changed, 0);
        step();
        chk("R6 flag set", cts_changed, 1);
        repeat (3) step();
        chk("R6 flag sticky", cts_changed, 1);
        cts_chg_clr = 1'b1;
        step();
        cts_chg_clr = 1'b0;
        chk("R6 flag cleared", cts_changed, 0);
        cts_n_pin = 1'b1;
        repeat (3) step();
        chk("R6 rising edge flag", cts_changed, 1);
        chk("R5 cts_off deasserted", cts_off, 1);
        cts_chg_clr = 1'b1;
        step();
        cts_chg_clr = 1'b0;

        // R7 hold only at a character boundary
        ctrl = mk(0, 1, 0, 0, 0, 4'd0, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 no hold mid-character", tx_hold, 0);
        end
        tx_char_done = 1'b1;
        step();
        tx_char_done = 1'b0;
        chk("R7 hold at boundary", tx_hold, 1);
        step();
        chk("R7 hold kept", tx_hold, 1);
        cts_n_pin = 1'b0;
        step();
        step();
        chk("R7 hold before sync", tx_hold, 1);
        step();
        chk("R7 hold released", tx_hold, 0);

        // R8 gate disabled
        cts_n_pin = 1'b1;
        ctrl = '0;
        repeat (3) step();
        tx_char_done = 1'b1;
        step();
        step();
        tx_char_done = 1'b0;
        chk("R8 no hold without gate", tx_hold, 0);

        // R9 / R10 break and direction disables
        for (int k = 0; k < 8; k++) begin
            ctrl = mk(0, 0, 0, k[1], k[2], 4'd0, k[0]);
            step();
            chk("R9 brk_force", brk_force, k[0]);
            chk("R10 rx_en", rx_en, k[1] ? 0 : 1);
            chk("R10 tx_en", tx_en, k[2] ? 0 : 1);
        end

        // R11 transmitter fully idle
        for (int k = 0; k < 4; k++) begin
            tx_fifo_empty = k[0];
            tx_shift_idle = k[1];
            step();
            chk("R11 tx_all_idle", tx_all_idle, (k == 3) ? 1 : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule